// File: doc/BRIEF.md
# Card Presence Debounce and Interrupt Controller

This block watches the mechanical switch of a smart-card connector and tells a host processor when a card goes in or comes out. The raw switch level is synchronised and then accepted only after it has held a new value for a fixed time window of 50 µs. The window is derived from the system clock frequency. Whether a closed switch means "card in" or "card out" is set by a polarity bit that the host writes while it holds chip select low.

An accepted insertion or removal pulls an active-low interrupt output low. A rising edge on any of three fault flags does the same: battery low, card supply low, and converter overload. The host acknowledges by raising chip select, or by raising the power-on input, which sends the interrupt back high. A two-bit select code chooses what the single status output shows, so that the host can poll the source of the interrupt. All inputs are taken as synchronous to `clk` except the switch input, which is synchronised inside the block.

Top module: `card_detect_irq`

## Requirements
- R1: After reset, irq_n is 1, the polarity is normally-open (pol_nc = 0 behaviour) and card_present is 0 while det_raw idles high.
- R2: A new det_raw level is accepted only after it has held for the debounce window, in both directions. A pulse shorter than the window changes neither card_present nor irq_n.
- R3: With normally-open polarity, an accepted low level of det_raw means a card is present (insertion is a falling edge) and an accepted high level means no card.
- R4: With normally-closed polarity (pol_nc = 1 written), an accepted high level of det_raw means a card is present and an accepted low level means no card.
- R5: Changing the polarity never raises the interrupt, even when the new polarity makes the current switch level read as a card already present.
- R6: An accepted insertion or removal drives irq_n to 0, and it stays 0 until cleared.
- R7: A 0-to-1 transition on batt_low, vcc_low or conv_ovl drives irq_n to 0. A flag that stays at 1 does not raise the interrupt again after a clear.
- R8: irq_n returns to 1 only on a rising edge of cs_n or of pwr_on. Holding cs_n low does not clear it.
- R9: An interrupt event in the same cycle as a clear edge leaves irq_n at 0.
- R10: status shows, by sel: 2'b00 card_present; 2'b01 batt_low (1 = battery low); 2'b10 the inverse of vcc_low (1 = card supply in range); 2'b11 the inverse of conv_ovl (1 = converter OK).
- R11: pol_wr loads pol_nc into the polarity register only while cs_n is 0. A write with cs_n at 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| det_raw | input | 1 | Raw connector switch level (asynchronous) |
| cs_n | input | 1 | Active-low chip select; its rising edge acknowledges the interrupt |
| pwr_on | input | 1 | Card power request; its rising edge also acknowledges |
| pol_wr | input | 1 | Polarity write strobe, taken when cs_n is 0 |
| pol_nc | input | 1 | Polarity value: 1 = normally-closed switch |
| sel | input | 2 | Status select code |
| batt_low | input | 1 | Battery undervoltage flag |
| vcc_low | input | 1 | Card supply undervoltage flag |
| conv_ovl | input | 1 | Converter overload flag |
| irq_n | output | 1 | Active-low interrupt |
| status | output | 1 | Selected status bit |
| card_present | output | 1 | Debounced card presence |

## Verification
The bench builds the block with CLK_HZ = 125000000 and DEBOUNCE_NS = 200, which gives a 25-cycle window in place of 6250. This makes it affordable to hold glitches just under the window on both edges, to perform repeated insertions and removals under both polarities, and to run the coincident event-and-clear case. The default 50 µs setting only changes the counter limit and width. Fault, acknowledge and polarity-write paths do not depend on the window, so they are covered the same way at either setting.

// File: rtl/cdi_pkg.sv
package cdi_pkg;

  typedef enum logic [1:0] {
    SEL_CARD = 2'b00,
    SEL_BATT = 2'b01,
    SEL_VCC  = 2'b10,
    SEL_CONV = 2'b11
  } stat_sel_e;

  localparam int FAULT_N = 3;

  // Clock cycles covering win_ns at f_hz, rounded up, at least one.
  function automatic int unsigned window_cycles(longint unsigned f_hz,
                                                longint unsigned win_ns);
    longint unsigned c;
    c = (f_hz * win_ns + 64'd999_999_999) / 64'd1_000_000_000;
    if (c < 64'd1) c = 64'd1;
    return int'(c);
  endfunction

  // Switch level to presence under the chosen polarity.
  function automatic logic level_means_card(logic lvl, logic nc);
    return nc ? lvl : ~lvl;
  endfunction

endpackage

// File: rtl/cdi_debounce.sv
module cdi_debounce #(
  parameter int unsigned DB_CYCLES = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic stable_o,
  output logic flip_o
);
  localparam int CW = $clog2(DB_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DB_CYCLES - 1);

  logic sync1, sync2;
  logic [CW-1:0] cnt;
  logic accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
    end else begin
      sync1 <= raw_i;
      sync2 <= sync1;
    end
  end

  assign accept = (sync2 != stable_o) && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      stable_o <= 1'b1;
      flip_o   <= 1'b0;
    end else begin
      flip_o <= accept;
      if (sync2 == stable_o) begin
        cnt <= '0;
      end else if (accept) begin
        stable_o <= sync2;
        cnt      <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2
  db_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stable_o != $past(stable_o)) |-> ($past(cnt) == LAST));

  // R2
  db_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flip_o |-> (stable_o != $past(stable_o)));

endmodule

// File: rtl/cdi_irq.sv
module cdi_irq
  import cdi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stable_i,
  input  logic               flip_i,
  input  logic               pol_nc_i,
  input  logic [FAULT_N-1:0] fault_i,
  input  logic               cs_n_i,
  input  logic               pwr_on_i,
  output logic               irq_n_o
);
  logic [FAULT_N-1:0] fault_q;
  logic cs_q, pwr_q;
  logic ins_evt, rem_evt, fault_evt, any_evt, clr_evt;
  logic now_card;

  assign now_card  = level_means_card(stable_i, pol_nc_i);
  assign ins_evt   = flip_i & now_card;
  assign rem_evt   = flip_i & ~now_card;
  assign fault_evt = |(fault_i & ~fault_q);
  assign any_evt   = ins_evt | rem_evt | fault_evt;
  assign clr_evt   = (cs_n_i & ~cs_q) | (pwr_on_i & ~pwr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= '0;
      cs_q    <= 1'b1;
      pwr_q   <= 1'b0;
      irq_n_o <= 1'b1;
    end else begin
      fault_q <= fault_i;
      cs_q    <= cs_n_i;
      pwr_q   <= pwr_on_i;
      if (any_evt)      irq_n_o <= 1'b0;
      else if (clr_evt) irq_n_o <= 1'b1;
    end
  end

  // R6 R7 R9
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |=> !irq_n_o);

  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n_o) |-> ($past(clr_evt) && !$past(any_evt)));

  // R5
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n_o) |-> $past(any_evt));

endmodule

// File: rtl/cdi_status.sv
module cdi_status
  import cdi_pkg::*;
(
  input  logic [1:0]         sel_i,
  input  logic               present_i,
  input  logic [FAULT_N-1:0] fault_i,
  output logic               status_o
);
  always_comb begin
    unique case (stat_sel_e'(sel_i))
      SEL_CARD: status_o = present_i;
      SEL_BATT: status_o = fault_i[0];
      SEL_VCC:  status_o = ~fault_i[1];
      SEL_CONV: status_o = ~fault_i[2];
      default:  status_o = present_i;
    endcase
  end
endmodule

// File: rtl/card_detect_irq.sv
module card_detect_irq
  import cdi_pkg::*;
#(
  parameter longint unsigned CLK_HZ      = 100_000_000,
  parameter longint unsigned DEBOUNCE_NS = 50_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       det_raw,
  input  logic       cs_n,
  input  logic       pwr_on,
  input  logic       pol_wr,
  input  logic       pol_nc,
  input  logic [1:0] sel,
  input  logic       batt_low,
  input  logic       vcc_low,
  input  logic       conv_ovl,
  output logic       irq_n,
  output logic       status,
  output logic       card_present
);
  localparam int unsigned DB_CYCLES = window_cycles(CLK_HZ, DEBOUNCE_NS);

  logic stable_lvl, flip;
  logic pol_q;
  logic [FAULT_N-1:0] faults;

  assign faults = {conv_ovl, vcc_low, batt_low};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pol_q <= 1'b0;
    else if (pol_wr && !cs_n) pol_q <= pol_nc;
  end

  cdi_debounce #(.DB_CYCLES(DB_CYCLES)) u_deb (
    .clk(clk), .rst_n(rst_n), .raw_i(det_raw),
    .stable_o(stable_lvl), .flip_o(flip)
  );

  cdi_irq u_irq (
    .clk(clk), .rst_n(rst_n), .stable_i(stable_lvl), .flip_i(flip),
    .pol_nc_i(pol_q), .fault_i(faults), .cs_n_i(cs_n),
    .pwr_on_i(pwr_on), .irq_n_o(irq_n)
  );

  assign card_present = level_means_card(stable_lvl, pol_q);

  cdi_status u_stat (
    .sel_i(sel), .present_i(card_present), .fault_i(faults),
    .status_o(status)
  );

  // R11
  pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> $stable(pol_q));

endmodule

// File: tb/test_card_detect_irq.sv
`timescale 1ns/1ps
module test_card_detect_irq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic det_raw = 1'b1, cs_n = 1'b1, pwr_on = 1'b0, pol_wr = 1'b0, pol_nc = 1'b0;
  logic [1:0] sel = 2'b00;
  logic batt_low = 1'b0, vcc_low = 1'b0, conv_ovl = 1'b0;
  logic irq_n, status, card_present;

  always #4 clk = ~clk;

  card_detect_irq #(.CLK_HZ(125_000_000), .DEBOUNCE_NS(200)) i_card_detect_irq (
    .clk(clk), .rst_n(rst_n), .det_raw(det_raw), .cs_n(cs_n), .pwr_on(pwr_on),
    .pol_wr(pol_wr), .pol_nc(pol_nc), .sel(sel), .batt_low(batt_low),
    .vcc_low(vcc_low), .conv_ovl(conv_ovl), .irq_n(irq_n), .status(status),
    .card_present(card_present)
  );

  typedef enum int {S_IRQ, S_PRES, S_STAT} sig_e;
  typedef struct { sig_e sig; logic exp; string req; } item_t;
  item_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  localparam int WIN = 25;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_bit(input sig_e s, input logic e, input string r);
    item_t it;
    it.sig = s; it.exp = e; it.req = r;
    q.push_back(it);
    tick(1);
  endtask

  // monitor: compares queued expectations away from the edge
  always @(posedge clk) begin
    #2;
    while (q.size() > 0) begin
      item_t it;
      logic act;
      it = q.pop_front();
      case (it.sig)
        S_IRQ:   act = irq_n;
        S_PRES:  act = card_present;
        default: act = status;
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s sig=%s actual=%b expected=%b", it.req, it.sig.name(), act, it.exp);
      end
    end
  end

  task automatic ack_cs();
    cs_n = 1'b0; tick(3); cs_n = 1'b1; tick(3);
  endtask

  task automatic write_pol(input logic v, input logic use_cs);
    cs_n = ~use_cs; pol_nc = v; pol_wr = 1'b1; tick(1);
    pol_wr = 1'b0; cs_n = 1'b1; tick(3);
  endtask

  initial begin
    tick(3); rst_n = 1'b1; tick(5);
    // R1 reset state
    expect_bit(S_IRQ, 1'b1, "R1");
    expect_bit(S_PRES, 1'b0, "R1");
    expect_bit(S_STAT, 1'b0, "R1");

    // R2 short low glitch rejected
    det_raw = 1'b0; tick(WIN - 8); det_raw = 1'b1; tick(40);
    expect_bit(S_PRES, 1'b0, "R2");
    expect_bit(S_IRQ, 1'b1, "R2");

    // R3 R6 insertion under normally-open
    det_raw = 1'b0; tick(40);
    expect_bit(S_PRES, 1'b1, "R3");
    expect_bit(S_IRQ, 1'b0, "R6");
    sel = 2'b00; expect_bit(S_STAT, 1'b1, "R10");

    // R8 low chip select does not clear, rising edge does
    cs_n = 1'b0; tick(4);
    expect_bit(S_IRQ, 1'b0, "R8");
    cs_n = 1'b1; tick(3);
    expect_bit(S_IRQ, 1'b1, "R8");

    // R2 short high glitch on removal side rejected
    det_raw = 1'b1; tick(WIN - 8); det_raw = 1'b0; tick(40);
    expect_bit(S_PRES, 1'b1, "R2");
    expect_bit(S_IRQ, 1'b1, "R2");

    // R3 R6 removal, R8 clear by power-on edge
    det_raw = 1'b1; tick(40);
    expect_bit(S_PRES, 1'b0, "R3");
    expect_bit(S_IRQ, 1'b0, "R6");
    pwr_on = 1'b1; tick(3);
    expect_bit(S_IRQ, 1'b1, "R8");
    pwr_on = 1'b0; tick(3);
    expect_bit(S_IRQ, 1'b1, "R8");

    // R7 R10 battery fault
    batt_low = 1'b1; tick(3);
    expect_bit(S_IRQ, 1'b0, "R7");
    sel = 2'b01; expect_bit(S_STAT, 1'b1, "R10");
    ack_cs();
    expect_bit(S_IRQ, 1'b1, "R8");
    tick(5);
    expect_bit(S_IRQ, 1'b1, "R7");

    // R7 R10 card supply low
    vcc_low = 1'b1; tick(3);
    expect_bit(S_IRQ, 1'b0, "R7");
    sel = 2'b10; expect_bit(S_STAT, 1'b0, "R10");
    ack_cs();

    // R7 R10 converter overload
    conv_ovl = 1'b1; tick(3);
    expect_bit(S_IRQ, 1'b0, "R7");
    sel = 2'b11; expect_bit(S_STAT, 1'b0, "R10");
    ack_cs();
    expect_bit(S_IRQ, 1'b1, "R8");

    batt_low = 1'b0; vcc_low = 1'b0; conv_ovl = 1'b0; tick(3);
    sel = 2'b11; expect_bit(S_STAT, 1'b1, "R10");
    sel = 2'b10; expect_bit(S_STAT, 1'b1, "R10");
    sel = 2'b01; expect_bit(S_STAT, 1'b0, "R10");
    expect_bit(S_IRQ, 1'b1, "R7");

    // R9 event coincides with clear edge
    vcc_low = 1'b1; tick(3);
    cs_n = 1'b0; tick(3);
    cs_n = 1'b1; batt_low = 1'b1; tick(4);
    expect_bit(S_IRQ, 1'b0, "R9");
    ack_cs();
    expect_bit(S_IRQ, 1'b1, "R9");
    batt_low = 1'b0; vcc_low = 1'b0; tick(3);

    // R11 polarity write with chip select high ignored
    sel = 2'b00;
    write_pol(1'b1, 1'b0);
    expect_bit(S_PRES, 1'b0, "R11");

    // R5 polarity change makes switch read as present, no interrupt
    write_pol(1'b1, 1'b1);
    expect_bit(S_PRES, 1'b1, "R5");
    expect_bit(S_IRQ, 1'b1, "R5");
    tick(5);
    expect_bit(S_IRQ, 1'b1, "R5");

    // R4 normally-closed removal and insertion
    det_raw = 1'b0; tick(40);
    expect_bit(S_PRES, 1'b0, "R4");
    expect_bit(S_IRQ, 1'b0, "R4");
    ack_cs();
    det_raw = 1'b1; tick(40);
    expect_bit(S_PRES, 1'b1, "R4");
    expect_bit(S_IRQ, 1'b0, "R4");
    expect_bit(S_STAT, 1'b1, "R10");

    tick(4);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule